// File: doc/BRIEF.md
# Parallel-Mode ADC Conversion Sequencer

This block is a synchronous controller for a 12-bit successive-approximation converter whose result comes out on a parallel bus. A pacing counter requests a conversion once per sample period. The controller then drives the active-low convert-start strobe for a fixed number of cycles and waits for the converter's active-low end-of-conversion pulse. When that pulse arrives it opens a read window and latches the word. A timeout covers a pulse that never comes. Every pulse width and wait is a cycle count, worked out by ceiling division from nanosecond parameters and the clock period.

The converter's input covers only the negative half of a bipolar range, so raw codes fall in the upper half of the code space. The controller inverts the top bit of the latched code, which maps the result to a zero-based unipolar value. Each finished word is staged. When the next conversion starts, the word is offered on an 8-bit valid/ready port: the lower eight bits first, then the upper four bits in a second transfer. A sticky flag records a word that arrived while its predecessor was still not fully taken, and a second sticky flag records a missing end-of-conversion pulse.

Top module: `adc_seq`

## Requirements
- R1: While reset is held, `cvt_start_n`, `rd_n` and `cs_n` are high, and `out_valid`, `err_overrun` and `err_timeout` are low.
- R2: Each convert-start pulse holds `cvt_start_n` low for exactly ceil(CONV_LOW_NS*1000/CLK_PS) cycles (5 with the defaults).
- R3: Successive falling edges of `cvt_start_n` are exactly ceil(PERIOD_NS*1000/CLK_PS) cycles apart (313 with the defaults, a 2.5 us sample period).
- R4: After a falling edge on `eoc_n`, `rd_n` goes low within 4 cycles and stays low for exactly ceil(READ_NS*1000/CLK_PS) cycles (6 with the defaults). `cs_n` is low whenever `rd_n` is low. `rd_n` and `cvt_start_n` are never low together.
- R5: The latched word equals the `adc_db` value present at the end of the read window with bit 11 inverted (raw 2048..4095 becomes 0..2047).
- R6: On the falling edge of `cvt_start_n` that follows a capture, the previous word is offered. The first transfer carries word bits 7:0 in `out_data` with `out_hi` = 0. The second carries word bits 11:8 in `out_data[3:0]`, with `out_data[7:4]` = 0 and `out_hi` = 1. `out_valid` drops after the second transfer.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_hi` hold their values (unless a new word is loaded at a conversion start).
- R8: `cvt_start_n` never rises less than ceil(ACQ_NS*1000/CLK_PS) cycles (50) after the falling edge of `eoc_n`.
- R9: If `eoc_n` does not fall within ceil(TIMEOUT_NS*1000/CLK_PS) cycles (250) after convert-start rises, `err_timeout` sets and stays set. Conversions go on at the regular period.
- R10: If a word is captured while the previous word has not been fully transferred, `err_overrun` sets and stays set. The older word is replaced by the newer one at the next conversion start.
- R11: A conversion start that follows a sample with no capture offers no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc_n | input | 1 | Converter end-of-conversion, active low |
| adc_db | input | 12 | Converter parallel data bus |
| cvt_start_n | output | 1 | Convert-start strobe, active low |
| cs_n | output | 1 | Converter chip select, active low |
| rd_n | output | 1 | Converter read strobe, active low |
| out_data | output | 8 | Host data: low byte, then the upper nibble zero-extended |
| out_hi | output | 1 | High when `out_data` carries the upper part |
| out_valid | output | 1 | Host data valid |
| out_ready | input | 1 | Host accepts data |
| err_overrun | output | 1 | Sticky overrun flag |
| err_timeout | output | 1 | Sticky missing end-of-conversion flag |

## Verification
The assertions assume that the converter lowers `eoc_n` only while a conversion is pending. They also assume the end-of-conversion pulse spans the synchronizer, and that no capture lands on the same edge as a conversion start. The bench converter model produces one 8-cycle pulse 200 cycles after each convert-start rise, or none when a timeout is being forced. Since 200 cycles plus the read and acquisition windows fit well inside the period, captures and starts never meet. The host ready line is random from a fixed seed, apart from one window held low to force an overrun. Data codes are random within the upper half-range, with both half-range ends placed directly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_READ
  } seq_state_t;

  // Ceiling conversion of a nanosecond span into clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CNT_W    = 9,
  parameter int CONV_CYC = 5,
  parameter int READ_CYC = 6,
  parameter int ACQ_CYC  = 50,
  parameter int TOUT_CYC = 250,
  parameter bit CS_TIED  = 1'b0,
  parameter bit FLIP_MSB = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              eoc_n,
  input  logic [DATA_W-1:0] db,
  output logic              convst_n,
  output logic              rd_n,
  output logic              cs_n,
  output logic              start_stb,
  output logic              cap_stb,
  output logic [DATA_W-1:0] cap_word,
  output logic              timeout
);

  seq_state_t state_q, state_d;
  logic convst_q, convst_d, rd_q, rd_d, to_q, to_d;
  logic cap_q, cap_d;
  logic [DATA_W-1:0] word_q, word_fix;
  logic eoc_s1, eoc_s2, eoc_s3, eoc_fall;
  logic ph_load, ph_zero, acq_load, acq_zero;
  logic [CNT_W-1:0] ph_val;

  adc_seq_cnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  adc_seq_cnt #(.W(CNT_W)) u_acq (
    .clk(clk), .rst_n(rst_n), .load(acq_load), .load_val(CNT_W'(ACQ_CYC)), .zero(acq_zero)
  );

  // End-of-conversion synchronizer and falling-edge detect.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_s1 <= 1'b1;
      eoc_s2 <= 1'b1;
      eoc_s3 <= 1'b1;
    end else begin
      eoc_s1 <= eoc_n;
      eoc_s2 <= eoc_s1;
      eoc_s3 <= eoc_s2;
    end
  end
  assign eoc_fall = eoc_s3 & ~eoc_s2;

  always_comb begin
    state_d   = state_q;
    convst_d  = convst_q;
    rd_d      = rd_q;
    to_d      = to_q;
    cap_d     = 1'b0;
    start_stb = 1'b0;
    ph_load   = 1'b0;
    ph_val    = '0;
    acq_load  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_req && acq_zero) begin
          start_stb = 1'b1;
          convst_d  = 1'b0;
          ph_load   = 1'b1;
          ph_val    = CNT_W'(CONV_CYC - 1);
          state_d   = ST_CONV;
        end
      end
      ST_CONV: begin
        if (ph_zero) begin
          convst_d = 1'b1;
          ph_load  = 1'b1;
          ph_val   = CNT_W'(TOUT_CYC - 1);
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (eoc_fall) begin
          rd_d     = 1'b0;
          ph_load  = 1'b1;
          ph_val   = CNT_W'(READ_CYC - 1);
          acq_load = 1'b1;
          state_d  = ST_READ;
        end else if (ph_zero) begin
          to_d     = 1'b1;
          acq_load = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_READ: begin
        if (ph_zero) begin
          rd_d    = 1'b1;
          cap_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  generate
    if (FLIP_MSB) begin : g_flip
      assign word_fix = {~db[DATA_W-1], db[DATA_W-2:0]};
    end else begin : g_raw
      assign word_fix = db;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      convst_q <= 1'b1;
      rd_q     <= 1'b1;
      to_q     <= 1'b0;
      cap_q    <= 1'b0;
      word_q   <= '0;
    end else begin
      state_q  <= state_d;
      convst_q <= convst_d;
      rd_q     <= rd_d;
      to_q     <= to_d;
      cap_q    <= cap_d;
      if (cap_d) begin
        word_q <= word_fix;
      end
    end
  end

  generate
    if (CS_TIED) begin : g_cs_tied
      assign cs_n = 1'b0;
    end else begin : g_cs_strobe
      logic cs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_q <= 1'b1;
        end else begin
          cs_q <= rd_d;
        end
      end
      assign cs_n = cs_q;
    end
  endgenerate

  assign convst_n = convst_q;
  assign rd_n     = rd_q;
  assign cap_stb  = cap_q;
  assign cap_word = word_q;
  assign timeout  = to_q;

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n) !(!convst_q && !rd_q)); // R4
  AST_CS_WITH_RD: assert property (@(posedge clk) disable iff (!rst_n) !rd_q |-> !cs_n); // R4
  AST_CAP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) cap_q |-> $past(!rd_q)); // R5
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) to_q |=> to_q); // R9
  AST_ACQ_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n) $fell(convst_q) |-> $past(acq_zero)); // R8

endmodule

// File: rtl/adc_seq_outbuf.sv
module adc_seq_outbuf #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stb,
  input  logic [DATA_W-1:0] cap_word,
  input  logic              start_stb,
  input  logic              host_ready,
  output logic [BYTE_W-1:0] host_data,
  output logic              host_hi,
  output logic              host_valid,
  output logic              overrun
);

  logic [DATA_W-1:0] stage_q, stage_d, buf_q, buf_d;
  logic stage_vld_q, stage_vld_d, avail_q, avail_d, hi_q, hi_d, ovr_q, ovr_d;

  always_comb begin
    stage_d     = stage_q;
    stage_vld_d = stage_vld_q;
    buf_d       = buf_q;
    avail_d     = avail_q;
    hi_d        = hi_q;
    ovr_d       = ovr_q;
    if (cap_stb) begin
      stage_d     = cap_word;
      stage_vld_d = 1'b1;
      if (avail_q || stage_vld_q) begin
        ovr_d = 1'b1;
      end
    end
    if (start_stb && stage_vld_q) begin
      buf_d       = stage_q;
      avail_d     = 1'b1;
      hi_d        = 1'b0;
      stage_vld_d = 1'b0;
    end else if (avail_q && host_ready) begin
      if (hi_q) begin
        avail_d = 1'b0;
        hi_d    = 1'b0;
      end else begin
        hi_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= '0;
      stage_vld_q <= 1'b0;
      buf_q       <= '0;
      avail_q     <= 1'b0;
      hi_q        <= 1'b0;
      ovr_q       <= 1'b0;
    end else begin
      stage_q     <= stage_d;
      stage_vld_q <= stage_vld_d;
      buf_q       <= buf_d;
      avail_q     <= avail_d;
      hi_q        <= hi_d;
      ovr_q       <= ovr_d;
    end
  end

  assign host_data  = hi_q ? BYTE_W'(buf_q >> BYTE_W) : buf_q[BYTE_W-1:0];
  assign host_hi    = hi_q;
  assign host_valid = avail_q;
  assign overrun    = ovr_q;

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovr_q |=> ovr_q); // R10
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_q && !host_ready && !start_stb) |=> (avail_q && $stable(host_data) && $stable(hi_q))); // R7
  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> $past(avail_q && host_ready)); // R6

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CLK_PS      = 8000,
  parameter int CONV_LOW_NS = 40,
  parameter int READ_NS     = 48,
  parameter int ACQ_NS      = 400,
  parameter int PERIOD_NS   = 2500,
  parameter int TIMEOUT_NS  = 2000,
  parameter bit CS_TIED     = 1'b0,
  parameter bit FLIP_MSB    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eoc_n,
  input  logic [DATA_W-1:0] adc_db,
  output logic              cvt_start_n,
  output logic              cs_n,
  output logic              rd_n,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_hi,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              err_overrun,
  output logic              err_timeout
);

  localparam int CONV_CYC = int'(ns_to_cyc(CONV_LOW_NS, CLK_PS));
  localparam int READ_CYC = int'(ns_to_cyc(READ_NS, CLK_PS));
  localparam int ACQ_CYC  = int'(ns_to_cyc(ACQ_NS, CLK_PS));
  localparam int PER_CYC  = int'(ns_to_cyc(PERIOD_NS, CLK_PS));
  localparam int TOUT_CYC = int'(ns_to_cyc(TIMEOUT_NS, CLK_PS));
  localparam int MAX_CYC  = (PER_CYC > TOUT_CYC) ? PER_CYC : TOUT_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic tick, pend_q, pend_d, start_req, start_stb, cap_stb;
  logic [DATA_W-1:0] cap_word;

  adc_seq_cnt #(.W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .load(tick), .load_val(CNT_W'(PER_CYC - 1)), .zero(tick)
  );

  assign start_req = pend_q | tick;

  always_comb begin
    pend_d = start_req & ~start_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  adc_seq_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CONV_CYC(CONV_CYC), .READ_CYC(READ_CYC),
    .ACQ_CYC(ACQ_CYC), .TOUT_CYC(TOUT_CYC), .CS_TIED(CS_TIED), .FLIP_MSB(FLIP_MSB)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .eoc_n(eoc_n), .db(adc_db),
    .convst_n(cvt_start_n), .rd_n(rd_n), .cs_n(cs_n), .start_stb(start_stb),
    .cap_stb(cap_stb), .cap_word(cap_word), .timeout(err_timeout)
  );

  adc_seq_outbuf #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_word(cap_word),
    .start_stb(start_stb), .host_ready(out_ready), .host_data(out_data),
    .host_hi(out_hi), .host_valid(out_valid), .overrun(err_overrun)
  );

endmodule

// File: tb/adc_seq_test.sv
module adc_seq_test;

  localparam int CLK_PS   = 8000;
  localparam int CONV_CYC = (40 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int READ_CYC = (48 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int ACQ_CYC  = (400 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int PER_CYC  = (2500 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int ADC_CONV = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoc_n = 1'b1;
  logic [11:0] adc_db = 12'h800;
  logic out_ready = 1'b0;
  logic cvt_start_n, cs_n, rd_n, out_hi, out_valid, err_overrun, err_timeout;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  adc_seq uut (
    .clk(clk), .rst_n(rst_n), .eoc_n(eoc_n), .adc_db(adc_db),
    .cvt_start_n(cvt_start_n), .cs_n(cs_n), .rd_n(rd_n), .out_data(out_data),
    .out_hi(out_hi), .out_valid(out_valid), .out_ready(out_ready),
    .err_overrun(err_overrun), .err_timeout(err_timeout)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] unipolar(input logic [11:0] raw);
    return raw ^ 12'h800;
  endfunction

  // Bench state
  int ready_mode = 0;
  bit skip_eoc = 1'b0;
  int fall_cnt = 0;
  int cyc = 0, last_fall = -1, cv_low = 0, rd_low = 0;
  int conv_tmr = -1, eoc_tmr = 0, since_eoc = 100000, eoc_to_rd = -1;
  int samp = 0;
  logic prev_cv = 1'b1, prev_rd = 1'b1;
  bit pend_to = 1'b0, exp_to = 1'b0, exp_ovr = 1'b0;
  bit stage_pend = 1'b0, exp_avail = 1'b0, exp_hi = 1'b0;
  logic [11:0] stage_w = '0, exp_w = '0;
  bit prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic prev_hi = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(cvt_start_n && rd_n && cs_n, "R1 strobes idle", {cvt_start_n, rd_n, cs_n}, 7);
      chk(!out_valid && !err_overrun && !err_timeout, "R1 flags clear",
          {out_valid, err_overrun, err_timeout}, 0);
    end else begin
      bit fell;
      cyc++;
      since_eoc++;
      fell = prev_cv && !cvt_start_n;
      // converter model
      if (!prev_cv && cvt_start_n) begin
        chk(cv_low == CONV_CYC, "R2 convert-start width", cv_low, CONV_CYC);
        if (since_eoc < 100000)
          chk(since_eoc >= ACQ_CYC, "R8 acquisition", since_eoc, ACQ_CYC);
        if (skip_eoc) begin
          pend_to = 1'b1;
          conv_tmr = -1;
        end else begin
          conv_tmr = ADC_CONV;
        end
      end
      if (conv_tmr > 0) conv_tmr--;
      if (conv_tmr == 0) begin
        logic [11:0] raw;
        conv_tmr = -1;
        raw = {1'b1, 11'($urandom)};
        if (samp == 2) raw = 12'h800;
        if (samp == 3) raw = 12'hFFF;
        samp++;
        adc_db = raw;
        eoc_n = 1'b0;
        eoc_tmr = 8;
        since_eoc = 0;
        eoc_to_rd = 0;
        if (exp_avail || stage_pend) exp_ovr = 1'b1;
        stage_w = unipolar(raw);
        stage_pend = 1'b1;
      end else if (eoc_tmr > 0) begin
        eoc_tmr--;
        if (eoc_tmr == 0) eoc_n = 1'b1;
      end
      // read strobe
      if (eoc_to_rd >= 0) begin
        if (!rd_n) begin
          chk(eoc_to_rd >= 1 && eoc_to_rd <= 4, "R4 read latency", eoc_to_rd, 3);
          eoc_to_rd = -1;
        end else begin
          eoc_to_rd++;
        end
      end
      if (!rd_n) begin
        rd_low++;
        if (cs_n) chk(1'b0, "R4 cs_n low during read", cs_n, 0);
        if (!cvt_start_n) chk(1'b0, "R4 strobes overlap", 1, 0);
      end
      if (!prev_rd && rd_n) begin
        chk(rd_low == READ_CYC, "R4 read width", rd_low, READ_CYC);
        rd_low = 0;
      end
      if (!cvt_start_n) cv_low++; else if (prev_cv == 1'b0) cv_low = 0;
      // start events
      if (fell) begin
        fall_cnt++;
        if (last_fall >= 0) chk(cyc - last_fall == PER_CYC, "R3 period", cyc - last_fall, PER_CYC);
        last_fall = cyc;
        exp_to = exp_to | pend_to;
        pend_to = 1'b0;
        chk(err_timeout == exp_to, "R9 timeout flag", err_timeout, exp_to);
        chk(err_overrun == exp_ovr, "R10 overrun flag", err_overrun, exp_ovr);
        if (stage_pend) begin
          exp_w = stage_w;
          exp_avail = 1'b1;
          exp_hi = 1'b0;
          stage_pend = 1'b0;
        end else begin
          chk(out_valid == exp_avail, "R11 no word without capture", out_valid, exp_avail);
        end
      end
      if (prev_stall && !fell) begin
        chk(out_valid && out_data == prev_data && out_hi == prev_hi, "R7 hold while stalled",
            out_data, prev_data);
      end
      // host side
      if (ready_mode == 0) out_ready = 1'($urandom);
      else out_ready = 1'b0;
      chk(out_valid == exp_avail, "R6 valid", out_valid, exp_avail);
      if (out_valid && out_ready && exp_avail) begin
        if (!exp_hi) begin
          chk(out_data == exp_w[7:0] && !out_hi, "R5 R6 low byte", out_data, exp_w[7:0]);
          exp_hi = 1'b1;
        end else begin
          chk(out_data == {4'h0, exp_w[11:8]} && out_hi, "R5 R6 high nibble", out_data,
              {4'h0, exp_w[11:8]});
          exp_hi = 1'b0;
          exp_avail = 1'b0;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
      prev_hi = out_hi;
    end
    prev_cv = cvt_start_n;
    prev_rd = rd_n;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait (fall_cnt >= 8);
    ready_mode = 1;
    wait (fall_cnt >= 11);
    @(negedge clk);
    chk(err_overrun == 1'b1, "R10 overrun after stalled host", err_overrun, 1);
    ready_mode = 0;
    wait (fall_cnt >= 12);
    skip_eoc = 1'b1;
    wait (fall_cnt >= 13);
    skip_eoc = 1'b0;
    @(negedge clk);
    chk(err_timeout == 1'b1, "R9 timeout after missing pulse", err_timeout, 1);
    wait (fall_cnt >= 17);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

endmodule